// File: doc/BRIEF.md
# Synchronous Burst SRAM with Four-Beat Sequencer

A single-port static memory, 18 bits wide and 2^ADDR_W words deep. The full part is 64K deep, and simulation uses a smaller default. Every input except the output enable is captured on the rising clock edge: the address, the write data, the two lane write enables, the chip enable and the three burst controls. An access starts in one of two ways. The processor start always reads. The controller start reads or writes at once, and which one depends on the lane write enables. After a start, the burst-advance input either steps the two lowest address bits through a binary four-beat sequence or holds them to insert a wait state.

The chip enable only matters on a cycle where a start input is low. If it is high on such a cycle, the memory is deselected. It then stays idle until a later start loads a new base address with the chip enable low. The read path is split into a data bus and a separate drive-enable output, so the pad tristate logic can sit outside the block. The enable follows the asynchronous output-enable pin and is forced off during writes.

Top module: `sburst_sram`

## Requirements
- R1: While reset is high, and after it is released, no access is active and `rdata_oe_o` is 0.
- R2: A clock edge with `cpu_start_n` low and `ce_n` low does the following:
  - It loads `addr_i` as the new base address and aborts any burst in progress.
  - It performs a read, whatever `ctl_start_n` and the lane write enables are doing.
- R3: A write started by the processor start takes two cycles. The first cycle has `cpu_start_n` low with the address. The second cycle has both start inputs high, `adv_n` high and one or both lane write enables low, and it writes `wdata_i` at the loaded address.
- R4: A clock edge with `cpu_start_n` high, `ctl_start_n` low and `ce_n` low loads `addr_i` and aborts any burst. It writes if either lane write enable is low and reads otherwise.
- R5: A clock edge with either start input low and `ce_n` high deselects the memory, so no access occurs and `rdata_oe_o` is 0. On cycles where both start inputs are high, `ce_n` is ignored.
- R6: On a continue cycle (both starts high) of an active burst, `adv_n` low increments address bits 1:0 as a two-bit binary counter before the access. Bits ADDR_W-1:2 stay fixed, and after four increments the address is back at its starting value.
- R7: On a continue cycle of an active burst, `adv_n` high keeps the current address, and a read or write is still performed there.
- R8: The lane write enables act on separate halves of the word:
  - `wen_lo_n` low writes data bits 8:0.
  - `wen_hi_n` low writes bits 17:9.
  - The lane that is not enabled keeps its stored value.
- R9: `rdata_oe_o` is 1 exactly when the current access is an active read and `oe_n` is low. It follows `oe_n` without waiting for a clock edge, and it is 0 during a write whatever `oe_n` is.
- R10: While deselected, continue cycles neither write nor advance the address. This holds even with write enables low and `adv_n` low.
- R11: The read data for the access captured at a clock edge is on `rdata_o` before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 18 | Write data |
| cpu_start_n | input | 1 | Processor transfer start, active low, read only |
| ctl_start_n | input | 1 | Controller transfer start, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| wen_lo_n | input | 1 | Write enable for bits 8:0, active low |
| wen_hi_n | input | 1 | Write enable for bits 17:9, active low |
| ce_n | input | 1 | Chip enable, active low, sampled only with a start |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 18 | Read data (zero when not driven) |
| rdata_oe_o | output | 1 | Drive enable for the external data tristate |

## Verification
The hardest case to reach is a deselected memory that sees continue cycles with write enables and advance asserted. Nothing changes at the outputs then, so the bench reads the old burst's addresses back afterwards to show that no write landed.

Wraparound that must not carry into bit 2 also needs care. Bursts start from every offset inside a block whose neighbouring block holds different data. Aborts are placed in the middle of a burst, and each start input is used to abort.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CMD_DESEL   = 2'd0,
        CMD_LOAD_RD = 2'd1,
        CMD_LOAD_RW = 2'd2,
        CMD_CONT    = 2'd3
    } cmd_e;

    typedef struct packed {
        logic             active;
        logic [LANES-1:0] lane_we;
    } access_t;

    function automatic logic [BEAT_W-1:0] beat_next(input logic [BEAT_W-1:0] cur,
                                                    input logic hold);
        return hold ? cur : cur + 1'b1;
    endfunction

    function automatic logic is_write(input access_t acc);
        return acc.active && (|acc.lane_we);
    endfunction

endpackage

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cpu_start_n,
    input  logic              ctl_start_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  wen_n,
    input  logic              ce_n,
    output access_t           acc_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int BASE_W = ADDR_W - BEAT_W;

    cmd_e              cmd;
    access_t           acc_q;
    logic [BASE_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;

    always_comb begin
        if (!cpu_start_n)      cmd = ce_n ? CMD_DESEL : CMD_LOAD_RD;
        else if (!ctl_start_n) cmd = ce_n ? CMD_DESEL : CMD_LOAD_RW;
        else                   cmd = CMD_CONT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            base_q <= '0;
            beat_q <= '0;
        end else begin
            case (cmd)
                CMD_DESEL: begin
                    acc_q.active  <= 1'b0;
                    acc_q.lane_we <= '0;
                end
                CMD_LOAD_RD: begin
                    acc_q.active  <= 1'b1;
                    acc_q.lane_we <= '0;
                    base_q        <= addr_i[ADDR_W-1:BEAT_W];
                    beat_q        <= addr_i[BEAT_W-1:0];
                end
                CMD_LOAD_RW: begin
                    acc_q.active  <= 1'b1;
                    acc_q.lane_we <= ~wen_n;
                    base_q        <= addr_i[ADDR_W-1:BEAT_W];
                    beat_q        <= addr_i[BEAT_W-1:0];
                end
                default: begin
                    if (acc_q.active) begin
                        beat_q        <= beat_next(beat_q, adv_n);
                        acc_q.lane_we <= ~wen_n;
                    end else begin
                        acc_q.lane_we <= '0;
                    end
                end
            endcase
        end
    end

    assign acc_o  = acc_q;
    assign addr_o = {base_q, beat_q};

    // R2
    cpu_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_start_n && !ce_n) |=> (acc_q.active && acc_q.lane_we == '0));

    // R4
    ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_start_n && !ctl_start_n && !ce_n) |=>
        (acc_q.active && acc_q.lane_we == ~$past(wen_n)));

    // R5
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        ((!cpu_start_n || !ctl_start_n) && ce_n) |=> !acc_q.active);

    // R6
    burst_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_q.active && cpu_start_n && ctl_start_n && !adv_n) |=>
        ((beat_q == $past(beat_q) + 2'd1) && $stable(base_q)));

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_q.active && cpu_start_n && ctl_start_n && adv_n) |=>
        ($stable(beat_q) && $stable(base_q) && acc_q.active));

    // R10
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_q.active && cpu_start_n && ctl_start_n) |=>
        (!acc_q.active && $stable(beat_q) && acc_q.lane_we == '0));

endmodule

// File: rtl/sburst_array.sv
module sburst_array
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  access_t           acc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_din
        always_ff @(posedge clk) lane_q[l] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (acc_i.active) begin
            for (int l = 0; l < LANES; l++) begin
                if (acc_i.lane_we[l]) mem[addr_i][l*LANE_W +: LANE_W] <= lane_q[l];
            end
        end
    end

    assign rdata_o = mem[addr_i];

endmodule

// File: rtl/sburst_outdrv.sv
module sburst_outdrv
    import sburst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc_i,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              drive_o
);
    assign drive_o = acc_i.active && !is_write(acc_i) && !oe_n;
    assign rdata_o = drive_o ? rdata_i : '0;

    // R9
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        drive_o |-> !oe_n);

    // R9
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (|acc_i.lane_we) |-> !drive_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !drive_o);

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              cpu_start_n,
    input  logic              ctl_start_n,
    input  logic              adv_n,
    input  logic              wen_lo_n,
    input  logic              wen_hi_n,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rdata_oe_o
);
    access_t           acc;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] mem_rd;

    sburst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (addr_i),
        .cpu_start_n (cpu_start_n),
        .ctl_start_n (ctl_start_n),
        .adv_n       (adv_n),
        .wen_n       ({wen_hi_n, wen_lo_n}),
        .ce_n        (ce_n),
        .acc_o       (acc),
        .addr_o      (addr_q)
    );

    sburst_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .acc_i   (acc),
        .addr_i  (addr_q),
        .wdata_i (wdata_i),
        .rdata_o (mem_rd)
    );

    sburst_outdrv u_outdrv (
        .clk     (clk),
        .rst     (rst),
        .acc_i   (acc),
        .oe_n    (oe_n),
        .rdata_i (mem_rd),
        .rdata_o (rdata_o),
        .drive_o (rdata_oe_o)
    );

endmodule

// File: tb/test_sburst_sram.sv
module test_sburst_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [17:0]   wdata_i = '0;
    logic cpu_start_n = 1'b1, ctl_start_n = 1'b1, adv_n = 1'b1;
    logic wen_lo_n = 1'b1, wen_hi_n = 1'b1, ce_n = 1'b0, oe_n = 1'b1;
    logic [17:0]   rdata_o;
    logic          rdata_oe_o;

    sburst_sram #(.ADDR_W(AW)) i_sburst_sram (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
        .wen_lo_n(wen_lo_n), .wen_hi_n(wen_hi_n), .ce_n(ce_n), .oe_n(oe_n),
        .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    bit   m_active = 0;
    bit   m_wr = 0;
    int   m_addr = 0;
    logic [17:0] ref_mem [DEPTH];
    bit   kn_lo [DEPTH];
    bit   kn_hi [DEPTH];

    task automatic compare(input string tag);
        bit exp_oe;
        exp_oe = m_active && !m_wr && !oe_n;
        n_cmp++;
        if (rdata_oe_o !== exp_oe) begin
            n_bad++;
            $display("FAIL %s drive enable got %0b exp %0b", tag, rdata_oe_o, exp_oe);
        end
        if (exp_oe && kn_lo[m_addr]) begin
            n_cmp++;
            if (rdata_o[8:0] !== ref_mem[m_addr][8:0]) begin
                n_bad++;
                $display("FAIL %s low lane @%0h got %h exp %h", tag, m_addr,
                         rdata_o[8:0], ref_mem[m_addr][8:0]);
            end
        end
        if (exp_oe && kn_hi[m_addr]) begin
            n_cmp++;
            if (rdata_o[17:9] !== ref_mem[m_addr][17:9]) begin
                n_bad++;
                $display("FAIL %s high lane @%0h got %h exp %h", tag, m_addr,
                         rdata_o[17:9], ref_mem[m_addr][17:9]);
            end
        end
    endtask

    // one clock: pins are active-low values
    task automatic cyc(input bit cpu, input bit ctl, input bit adv, input bit wlo,
                       input bit whi, input bit ce, input bit oe, input int a,
                       input logic [17:0] d, input string tag);
        cpu_start_n = cpu; ctl_start_n = ctl; adv_n = adv;
        wen_lo_n = wlo; wen_hi_n = whi; ce_n = ce; oe_n = oe;
        addr_i = a[AW-1:0]; wdata_i = d;
        if (!cpu) begin
            if (ce) begin m_active = 0; m_wr = 0; end
            else begin m_active = 1; m_addr = a % DEPTH; m_wr = 0; end
        end else if (!ctl) begin
            if (ce) begin m_active = 0; m_wr = 0; end
            else begin m_active = 1; m_addr = a % DEPTH; m_wr = !(wlo && whi); end
        end else if (m_active) begin
            if (!adv) m_addr = (m_addr / 4) * 4 + ((m_addr + 1) % 4);
            m_wr = !(wlo && whi);
        end
        if (m_active && m_wr) begin
            if (!wlo) begin ref_mem[m_addr][8:0]  = d[8:0];  kn_lo[m_addr] = 1; end
            if (!whi) begin ref_mem[m_addr][17:9] = d[17:9]; kn_hi[m_addr] = 1; end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic oe_probe(input bit oe, input string tag);
        oe_n = oe;
        #1;
        compare(tag);
    endtask

    // controller-start write burst of four beats
    task automatic wr_burst(input int a, input logic [17:0] d, input string tag);
        cyc(1, 0, 1, 0, 0, 0, 1, a, d, tag);
        for (int k = 1; k < 4; k++)
            cyc(1, 1, 0, 0, 0, 0, 1, 0, d + 18'(k * 'h111), tag);
    endtask

    // read burst with n beats, started by the cpu (use_cpu) or controller start
    task automatic rd_burst(input bit use_cpu, input int a, input int n, input string tag);
        if (use_cpu) cyc(0, 1, 1, 1, 1, 0, 0, a, 0, tag);
        else         cyc(1, 0, 1, 1, 1, 0, 0, a, 0, tag);
        for (int k = 1; k < n; k++) cyc(1, 1, 0, 1, 1, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog got running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin kn_lo[i] = 0; kn_hi[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        oe_n = 1'b0;
        #1 compare("R1 in reset");
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        compare("R1 after reset");

        // controller-start write bursts covering neighbouring blocks
        for (int b = 0; b < 4; b++) wr_burst('h80 + 4 * b, 18'h01000 + 18'(b * 'h2468), "R4 write");
        wr_burst('h40, 18'h2A5A5, "R4 write");

        // full read bursts with wrap from every start offset
        rd_burst(1, 'h40, 5, "R6 wrap cpu");
        for (int off = 0; off < 4; off++) rd_burst(0, 'h84 + off, 6, "R6 wrap offset");
        rd_burst(0, 'h8F, 5, "R11 read flow");

        // wait states in a read burst and in a write burst
        cyc(1, 0, 1, 1, 1, 0, 0, 'h86, 0, "R7 read start");
        cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, "R7 read hold");
        cyc(1, 1, 0, 1, 1, 0, 0, 0, 0, "R7 read step");
        cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, "R7 read hold");
        cyc(1, 0, 1, 0, 0, 0, 1, 'h150, 18'h11111, "R7 write start");
        cyc(1, 1, 1, 0, 0, 0, 1, 0, 18'h22222, "R7 write hold");
        cyc(1, 1, 0, 0, 0, 0, 1, 0, 18'h33333, "R7 write step");
        rd_burst(0, 'h150, 4, "R7 readback");

        // processor-start two-cycle write; write enables ignored on the start cycle
        cyc(0, 0, 1, 0, 0, 0, 0, 'h100, 18'h3FFFF, "R2 start ignores writes");
        cyc(1, 1, 1, 0, 0, 0, 1, 0, 18'h1ABCD, "R3 second cycle write");
        cyc(0, 1, 1, 0, 0, 0, 0, 'h100, 18'h00000, "R3 readback");
        cyc(0, 1, 1, 1, 1, 0, 0, 'h40, 0, "R2 plain read");

        // lane writes
        cyc(1, 0, 1, 0, 1, 0, 1, 'h100, 18'h00055, "R8 low lane");
        cyc(1, 0, 1, 1, 0, 0, 1, 'h101, 18'h3FE00, "R8 high lane");
        cyc(1, 0, 1, 1, 0, 0, 1, 'h41, 18'h2AA00, "R8 high lane");
        rd_burst(1, 'h100, 2, "R8 readback");
        rd_burst(1, 'h40, 4, "R8 readback");

        // asynchronous output enable
        cyc(1, 0, 1, 1, 1, 0, 0, 'h84, 0, "R9 read");
        oe_probe(1, "R9 oe high");
        oe_probe(0, "R9 oe low");
        cyc(1, 0, 1, 0, 0, 0, 0, 'h160, 18'h0F0F0, "R9 write with oe low");
        oe_probe(1, "R9 write oe high");
        oe_probe(0, "R9 write oe low");

        // aborts mid-burst with each start
        cyc(1, 0, 1, 1, 1, 0, 0, 'h88, 0, "R4 abort setup");
        cyc(1, 1, 0, 1, 1, 0, 0, 0, 0, "R4 abort setup");
        cyc(0, 1, 1, 1, 1, 0, 0, 'h8E, 0, "R2 abort by cpu");
        cyc(1, 1, 0, 1, 1, 0, 0, 0, 0, "R2 after abort");
        cyc(1, 0, 1, 1, 1, 0, 0, 'h81, 0, "R4 abort by ctl");
        cyc(1, 1, 0, 1, 1, 0, 0, 0, 0, "R4 after abort");
        cyc(1, 0, 1, 0, 0, 0, 1, 'h8D, 18'h12345, "R4 write abort");
        rd_burst(0, 'h8C, 4, "R4 readback");

        // chip enable ignored on continue cycles
        cyc(1, 0, 1, 1, 1, 0, 0, 'h90, 0, "R5 start");
        cyc(1, 1, 0, 1, 1, 1, 0, 0, 0, "R5 ce ignored");
        cyc(1, 1, 0, 1, 1, 1, 0, 0, 0, "R5 ce ignored");

        // deselect, then continue cycles must not touch memory
        wr_burst('h200, 18'h0C0DE, "R10 setup");
        cyc(1, 0, 1, 1, 1, 1, 0, 'h200, 0, "R5 ctl deselect");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 18'h3FFFF, "R10 idle write");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 18'h3FFFF, "R10 idle write");
        cyc(1, 1, 1, 0, 0, 1, 0, 0, 18'h3FFFF, "R10 idle write");
        cyc(0, 1, 1, 1, 1, 1, 0, 'h200, 0, "R5 cpu deselect");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 18'h3FFFF, "R10 idle write");
        rd_burst(1, 'h200, 5, "R10 readback");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule